// File: doc/BRIEF.md
# Serial Latch-Select Control Port with Reference Divider

This block is the control front end of a dual-loop frequency synthesizer. A host writes 19-bit control words over three wires: a shift clock, a data line and a load strobe. The block samples all three wires on the oscillator clock. It shifts the data in on rising shift-clock edges. When the strobe rises, it transfers the captured word into one of three destination latches: the high-band loop divider, the low-band loop divider, or the reference divider together with two per-loop power bits.

The block also runs the reference counter. This counter divides the oscillator clock by the latched ratio R and gives one comparison pulse that both loops share. Each loop has a run pin, which is high for normal operation. A loop's enable output is the AND of its run pin and its serial power bit. As a result, the serial bit can only switch a loop off or on while that loop's pin is high.

Top module: `pll_serial_ctl`

## Requirements
- R1: A data bit is captured on each rising edge of `ser_clk` while `ser_le` is low. Words are 19 bits long and sent most significant bit first. The last two bits sent form the select code, which sits in word bits [1:0].
- R2: When `ser_le` rises and the select code is 00, `n_hi` takes word bits [18:2]. `n_lo`, `r_div` and both enables are left unchanged.
- R3: When `ser_le` rises and the select code is 01, `n_lo` takes word bits [18:2]. `n_hi`, `r_div` and both enables are left unchanged.
- R4: When `ser_le` rises and the select code is 10, the reference ratio takes word bits [12:2]. The high-band power bit takes word bit 13 and the low-band power bit takes word bit 14.
- R5: A word with select code 11 changes no output.
- R6: Each high period of `ser_le` performs exactly one transfer. `ser_clk` edges seen while `ser_le` is high do not alter the captured word.
- R7: A reference ratio below 5 is stored and used as 5. Ratios from 5 to 2047 are stored unchanged on `r_div`.
- R8: `ref_pulse` is high for exactly one clock cycle once every R clock cycles, where R is the current ratio.
- R9: A newly loaded ratio first sets the length of the period that begins at the next reference pulse. The period already running keeps the old length.
- R10: `en_hi` equals `run_hi` AND the high-band power bit. `en_lo` equals `run_lo` AND the low-band power bit.
- R11: After reset, `n_hi` and `n_lo` are 0, `r_div` is 5, and both power bits are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; samples the serial wires and drives the counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe; a rising edge transfers the word |
| run_hi | input | 1 | High-band run pin, high = operate |
| run_lo | input | 1 | Low-band run pin, high = operate |
| n_hi | output | 17 | High-band loop divide ratio |
| n_lo | output | 17 | Low-band loop divide ratio |
| r_div | output | 11 | Reference ratio in use (clamped) |
| en_hi | output | 1 | High-band loop enable |
| en_lo | output | 1 | Low-band loop enable |
| ref_pulse | output | 1 | Comparison pulse, one cycle every R cycles |

## Verification
The bench sweeps the reference ratio from 0 to 40 and also loads 2047. It times every gap between reference pulses against the ratio that was in force when the gap began. A design that clamped wrongly, reloaded off by one, or let a new ratio cut short the running period would produce a gap of the wrong length. The bench clocks extra bits while the strobe is high and then repeats the strobe alone. A design that kept shifting during the strobe would redirect that second transfer into the low-band latch. Select code 11 is also tried, and so is every combination of run pin and power bit, to expose a decoder that falls through to a latch or an enable that ignores one of its two terms.

// File: rtl/ser_ctl_pkg.sv
package ser_ctl_pkg;
   localparam int SEL_W = 2;

   typedef enum logic [SEL_W-1:0] {
      SEL_N_HI = 2'b00,
      SEL_N_LO = 2'b01,
      SEL_REF  = 2'b10,
      SEL_SKIP = 2'b11
   } sel_e;
endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= '0;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/ser_shift_in.sv
module ser_shift_in #(
   parameter int WORD_W      = 19,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_dat,
   input  logic              ser_le,
   output logic [WORD_W-1:0] word,
   output logic              load
);
   logic s_clk, s_dat, s_le;
   logic clk_d, le_d;
   logic [WORD_W-1:0] sr_q;
   logic load_q;
   logic sclk_rise, le_rise;

   ser_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({ser_clk, ser_dat, ser_le}),
      .q    ({s_clk, s_dat, s_le})
   );

   assign sclk_rise = s_clk & ~clk_d;
   assign le_rise   = s_le & ~le_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_d  <= 1'b0;
         le_d   <= 1'b0;
         sr_q   <= '0;
         load_q <= 1'b0;
      end else begin
         clk_d  <= s_clk;
         le_d   <= s_le;
         load_q <= le_rise;
         if (sclk_rise && !s_le) sr_q <= {sr_q[WORD_W-2:0], s_dat};
      end
   end

   assign word = sr_q;
   assign load = load_q;

   // R6: strobe high freezes the shift register
   assert_sr_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
      s_le |=> $stable(sr_q));
   // R6: one transfer per strobe
   assert_load_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      load_q |=> !load_q);
endmodule

// File: rtl/ser_latch_bank.sv
module ser_latch_bank
   import ser_ctl_pkg::*;
#(
   parameter int N_W   = 17,
   parameter int R_W   = 11,
   parameter int R_MIN = 5,
   localparam int WORD_W = N_W + SEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] word,
   input  logic              load,
   output logic [N_W-1:0]    n_hi,
   output logic [N_W-1:0]    n_lo,
   output logic [R_W-1:0]    r_div,
   output logic              pwr_hi,
   output logic              pwr_lo
);
   localparam logic [R_W-1:0] R_FLOOR = R_W'(R_MIN);
   localparam int PWR_HI_BIT = SEL_W + R_W;
   localparam int PWR_LO_BIT = SEL_W + R_W + 1;

   sel_e             sel;
   logic [N_W-1:0]   n_fld;
   logic [R_W-1:0]   r_fld, r_clamped;
   logic [N_W-1:0]   n_hi_q, n_lo_q;
   logic [R_W-1:0]   r_q;
   logic             ph_q, pl_q;

   assign sel       = sel_e'(word[SEL_W-1:0]);
   assign n_fld     = word[SEL_W+N_W-1:SEL_W];
   assign r_fld     = word[SEL_W+R_W-1:SEL_W];
   assign r_clamped = (r_fld < R_FLOOR) ? R_FLOOR : r_fld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         n_hi_q <= '0;
         n_lo_q <= '0;
         r_q    <= R_FLOOR;
         ph_q   <= 1'b1;
         pl_q   <= 1'b1;
      end else if (load) begin
         case (sel)
            SEL_N_HI: n_hi_q <= n_fld;
            SEL_N_LO: n_lo_q <= n_fld;
            SEL_REF: begin
               r_q  <= r_clamped;
               ph_q <= word[PWR_HI_BIT];
               pl_q <= word[PWR_LO_BIT];
            end
            default: ;
         endcase
      end
   end

   assign n_hi   = n_hi_q;
   assign n_lo   = n_lo_q;
   assign r_div  = r_q;
   assign pwr_hi = ph_q;
   assign pwr_lo = pl_q;

   assert_r_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
      r_q >= R_FLOOR);
   assert_skip_noop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (load && sel == SEL_SKIP) |=> ($stable(n_hi_q) && $stable(n_lo_q) &&
                                     $stable(r_q) && $stable(ph_q) && $stable(pl_q)));
   assert_hi_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (load && sel == SEL_N_HI) |=> ($stable(n_lo_q) && $stable(r_q)));
endmodule

// File: rtl/ref_divider.sv
module ref_divider #(
   parameter int R_W = 11
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [R_W-1:0] r_div,
   output logic           ref_pulse
);
   logic [R_W-1:0] cnt_q;
   logic           pulse_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         pulse_q <= 1'b0;
      end else if (cnt_q == '0) begin
         cnt_q   <= r_div - 1'b1;
         pulse_q <= 1'b1;
      end else begin
         cnt_q   <= cnt_q - 1'b1;
         pulse_q <= 1'b0;
      end
   end

   assign ref_pulse = pulse_q;

   assert_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0) |=> (cnt_q == $past(r_div) - 1'b1));
   assert_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |=> !pulse_q);
endmodule

// File: rtl/pll_serial_ctl.sv
module pll_serial_ctl
   import ser_ctl_pkg::*;
#(
   parameter int N_W         = 17,
   parameter int R_W         = 11,
   parameter int R_MIN       = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ser_clk,
   input  logic           ser_dat,
   input  logic           ser_le,
   input  logic           run_hi,
   input  logic           run_lo,
   output logic [N_W-1:0] n_hi,
   output logic [N_W-1:0] n_lo,
   output logic [R_W-1:0] r_div,
   output logic           en_hi,
   output logic           en_lo,
   output logic           ref_pulse
);
   localparam int WORD_W = N_W + SEL_W;

   generate
      if (R_W + 2 > N_W) begin : g_err_fields
         $error("reference field plus power bits must fit in the divider field");
      end
      if (R_MIN < 2 || R_MIN >= (1 << R_W)) begin : g_err_rmin
         $error("R_MIN must lie between 2 and the largest ratio");
      end
      if (SYNC_STAGES > 3) begin : g_err_sync
         $error("SYNC_STAGES above 3 is not supported");
      end
   endgenerate

   logic [WORD_W-1:0] word;
   logic              load;
   logic              pwr_hi, pwr_lo;

   ser_shift_in #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .ser_clk(ser_clk),
      .ser_dat(ser_dat),
      .ser_le (ser_le),
      .word   (word),
      .load   (load)
   );

   ser_latch_bank #(.N_W(N_W), .R_W(R_W), .R_MIN(R_MIN)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .word  (word),
      .load  (load),
      .n_hi  (n_hi),
      .n_lo  (n_lo),
      .r_div (r_div),
      .pwr_hi(pwr_hi),
      .pwr_lo(pwr_lo)
   );

   ref_divider #(.R_W(R_W)) u_ref (
      .clk      (clk),
      .rst_n    (rst_n),
      .r_div    (r_div),
      .ref_pulse(ref_pulse)
   );

   assign en_hi = run_hi & pwr_hi;
   assign en_lo = run_lo & pwr_lo;

   assert_gate_hi_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !run_hi |-> !en_hi);
   assert_gate_lo_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !run_lo |-> !en_lo);
endmodule

// File: tb/test_pll_serial_ctl.sv
module test_pll_serial_ctl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
   logic run_hi = 1'b1, run_lo = 1'b1;
   logic [16:0] n_hi, n_lo;
   logic [10:0] r_div;
   logic en_hi, en_lo, ref_pulse;

   int vectors = 0;
   int fails = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   pll_serial_ctl i_pll_serial_ctl (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le(ser_le),
      .run_hi(run_hi), .run_lo(run_lo), .n_hi(n_hi), .n_lo(n_lo), .r_div(r_div),
      .en_hi(en_hi), .en_lo(en_lo), .ref_pulse(ref_pulse)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Pulse monitor: each gap must equal the ratio visible when the gap began (R8, R9)
   int gap = 0;
   int exp_gap = 0;
   bit gap_valid = 0;
   int r_seen = 5;
   always @(negedge clk) begin
      if (!rst_n) begin
         gap_valid = 0;
         gap = 0;
         r_seen = int'(r_div);
      end else begin
         gap++;
         if (ref_pulse) begin
            if (gap_valid) chk(gap == exp_gap, "R8 R9 pulse gap", gap, exp_gap);
            exp_gap = r_seen;
            gap_valid = 1;
            gap = 0;
         end
         r_seen = int'(r_div);
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic shift_bit(input logic b);
      ser_dat = b;
      idle(3);
      ser_clk = 1'b1;
      idle(3);
      ser_clk = 1'b0;
   endtask

   task automatic strobe();
      idle(3);
      ser_le = 1'b1;
      idle(6);
      ser_le = 1'b0;
      idle(6);
   endtask

   task automatic send_word(input logic [18:0] w);
      for (int i = 18; i >= 0; i--) shift_bit(w[i]);
      strobe();
   endtask

   function automatic logic [18:0] w_n(input int n, input logic [1:0] sel);
      logic [16:0] nn;
      nn = n[16:0];
      return {nn, sel};
   endfunction

   function automatic logic [18:0] w_r(input int r, input bit ph, input bit pl);
      logic [10:0] rr;
      rr = r[10:0];
      return {4'b0000, pl, ph, rr, 2'b10};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      int hi_vals [5];
      int lo_vals [5];
      int saved_hi, saved_lo, saved_r;
      bit saved_ph, saved_pl;
      hi_vals = '{0, 1024, 131071, 87381, 43690};
      lo_vals = '{256, 131071, 1, 76543, 0};

      idle(4);
      rst_n = 1'b1;
      idle(2);
      // R11 reset state
      chk(n_hi == 0, "R11 n_hi reset", int'(n_hi), 0);
      chk(n_lo == 0, "R11 n_lo reset", int'(n_lo), 0);
      chk(r_div == 5, "R11 r_div reset", int'(r_div), 5);
      chk(en_hi == 1, "R11 en_hi reset", int'(en_hi), 1);
      chk(en_lo == 1, "R11 en_lo reset", int'(en_lo), 1);
      idle(30);

      // R1 R2: high-band word, MSB first, select 00
      foreach (hi_vals[k]) begin
         saved_lo = int'(n_lo);
         saved_r = int'(r_div);
         send_word(w_n(hi_vals[k], 2'b00));
         chk(int'(n_hi) == hi_vals[k], "R1 R2 n_hi load", int'(n_hi), hi_vals[k]);
         chk(int'(n_lo) == saved_lo, "R2 n_lo untouched", int'(n_lo), saved_lo);
         chk(int'(r_div) == saved_r, "R2 r_div untouched", int'(r_div), saved_r);
      end

      // R3: low-band word, select 01
      foreach (lo_vals[k]) begin
         saved_hi = int'(n_hi);
         send_word(w_n(lo_vals[k], 2'b01));
         chk(int'(n_lo) == lo_vals[k], "R3 n_lo load", int'(n_lo), lo_vals[k]);
         chk(int'(n_hi) == saved_hi, "R3 n_hi untouched", int'(n_hi), saved_hi);
      end

      // R4 R7 R10: reference sweep 0..40 with power bits from the ratio's low bits
      for (int r = 0; r <= 40; r++) begin
         int exp_r;
         exp_r = (r < 5) ? 5 : r;
         send_word(w_r(r, r[0], r[1]));
         chk(int'(r_div) == exp_r, "R4 R7 r_div", int'(r_div), exp_r);
         chk(en_hi == r[0], "R4 R10 en_hi power bit", int'(en_hi), r[0]);
         chk(en_lo == r[1], "R4 R10 en_lo power bit", int'(en_lo), r[1]);
      end

      // R7 R8: largest ratio, long periods measured by the monitor
      send_word(w_r(2047, 1'b1, 1'b1));
      chk(int'(r_div) == 2047, "R7 r_div max", int'(r_div), 2047);
      idle(2 * 2047 + 20);
      // R9: shrink the ratio while a long period is running
      send_word(w_r(6, 1'b1, 1'b1));
      chk(int'(r_div) == 6, "R9 r_div after shrink", int'(r_div), 6);
      idle(2 * 2047 + 20);

      // R5: select 11 changes nothing
      saved_hi = int'(n_hi);
      saved_lo = int'(n_lo);
      saved_r = int'(r_div);
      saved_ph = en_hi;
      saved_pl = en_lo;
      send_word(19'h7FFFF);
      chk(int'(n_hi) == saved_hi, "R5 n_hi", int'(n_hi), saved_hi);
      chk(int'(n_lo) == saved_lo, "R5 n_lo", int'(n_lo), saved_lo);
      chk(int'(r_div) == saved_r, "R5 r_div", int'(r_div), saved_r);
      chk(en_hi == saved_ph && en_lo == saved_pl, "R5 enables",
          int'({en_hi, en_lo}), int'({saved_ph, saved_pl}));

      // R6: shift clocks during the strobe are ignored; a bare strobe reloads the same word
      send_word(w_n(12345, 2'b00));
      saved_lo = int'(n_lo);
      idle(3);
      ser_le = 1'b1;
      idle(6);
      shift_bit(1'b0);
      shift_bit(1'b1);
      idle(3);
      ser_le = 1'b0;
      idle(6);
      strobe();
      chk(int'(n_hi) == 12345, "R6 n_hi kept", int'(n_hi), 12345);
      chk(int'(n_lo) == saved_lo, "R6 n_lo not redirected", int'(n_lo), saved_lo);

      // R10: every run pin and power bit combination
      for (int p = 0; p < 4; p++) begin
         send_word(w_r(9, p[0], p[1]));
         for (int q = 0; q < 4; q++) begin
            run_hi = q[0];
            run_lo = q[1];
            idle(1);
            chk(en_hi == (q[0] & p[0]), "R10 en_hi", int'(en_hi), int'(q[0] & p[0]));
            chk(en_lo == (q[1] & p[1]), "R10 en_lo", int'(en_lo), int'(q[1] & p[1]));
         end
         run_hi = 1'b1;
         run_lo = 1'b1;
      end
      idle(40);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule